// File: doc/BRIEF.md
# Signed-Digit Quotient Accumulator

This block assembles the quotient of an iterative divider whose digit selection produces one redundant digit per cycle, taken from {-1, 0, +1}. The usual way of applying a negative digit would subtract from the running value and ripple a borrow through every bit. Here no carry or borrow chain appears anywhere. The block keeps two registers side by side: the running quotient and a companion that always holds the running quotient minus one. On each accepted digit both registers shift left by one place and each takes a new low bit. When the digit is negative, the new quotient is built from the companion. When the digit is positive, the new companion is built from the old quotient.

The divider presents a digit together with a valid strobe on each cycle. It can restart the accumulation with a synchronous clear. After the last digit it reads the quotient directly, and the companion value is ready for any final correction step that lies outside this block. Both registers are `QW` bits wide. Weights beyond that width fall off the top, so the quotient is the digit sum reduced modulo 2^QW.

Top module: `otf_quotient_conv`

## Requirements
- R1: After reset, and in the cycle after `clear_i` is sampled high, `q_o` is 0 and `qm_o` is all ones. `clear_i` takes priority over a valid digit in the same cycle.
- R2: A valid digit with code 2'b00 (value 0) makes `q_o` equal to the old `q_o` shifted left with 0 appended. It makes `qm_o` equal to the old `qm_o` shifted left with 1 appended.
- R3: A valid digit with code 2'b01 (value +1) makes `q_o` equal to the old `q_o` shifted left with 1 appended. It makes `qm_o` equal to the old `q_o` shifted left with 0 appended.
- R4: A valid digit with code 2'b11 (value -1) makes `q_o` equal to the old `qm_o` shifted left with 1 appended. It makes `qm_o` equal to the old `qm_o` shifted left with 0 appended.
- R5: A valid digit with the reserved code 2'b10 leaves both outputs unchanged.
- R6: While `dig_valid_i` is low and `clear_i` is low, both outputs hold their values.
- R7: `qm_o` equals `q_o` minus one, modulo 2^QW, in every cycle.
- R8: After any digit sequence that follows a clear, `q_o` equals the sum of each digit times 2 to the power of its distance from the newest digit, reduced modulo 2^QW. This holds for sequences longer than QW digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart of the accumulation |
| dig_valid_i | input | 1 | Digit strobe; a digit is accepted when high |
| dig_code_i | input | 2 | Digit code: 00 = 0, 01 = +1, 11 = -1, 10 reserved |
| q_o | output | QW | Accumulated quotient |
| qm_o | output | QW | Accumulated quotient minus one |

## Verification
The assertions check, on every cycle, the single-step rules for each digit code, the hold behaviour for an idle strobe and for the reserved code, the effect of a clear, and the fixed offset of one between the two registers. Only the bench scenarios can show that long mixed digit streams produce the correct binary value. This includes streams that start with negative digits and streams long enough to wrap past the register width. The bench compares against an arithmetic reference for these cases.

// File: rtl/otf_pkg.sv
package otf_pkg;

    localparam logic [1:0] DIG_ZERO = 2'b00;
    localparam logic [1:0] DIG_PLUS = 2'b01;
    localparam logic [1:0] DIG_RSVD = 2'b10;
    localparam logic [1:0] DIG_MINUS = 2'b11;

    typedef enum logic [1:0] {
        KIND_ZERO  = 2'b00,
        KIND_PLUS  = 2'b01,
        KIND_HOLD  = 2'b10,
        KIND_MINUS = 2'b11
    } dig_kind_e;

    // Per-cycle steering derived from one digit
    typedef struct packed {
        logic upd;        // registers take a new value
        logic q_from_qm;  // new Q built from old QM
        logic qm_from_q;  // new QM built from old Q
        logic q_bit;      // bit appended to Q
        logic qm_bit;     // bit appended to QM
    } dig_sel_t;

endpackage

// File: rtl/otf_digit_decode.sv
module otf_digit_decode
    import otf_pkg::*;
(
    input  logic       valid_i,
    input  logic [1:0] code_i,
    output dig_sel_t   sel_o
);

    dig_kind_e kind;

    always_comb begin
        unique case (code_i)
            DIG_ZERO:  kind = KIND_ZERO;
            DIG_PLUS:  kind = KIND_PLUS;
            DIG_MINUS: kind = KIND_MINUS;
            default:   kind = KIND_HOLD;
        endcase
        if (!valid_i) kind = KIND_HOLD;
    end

    always_comb begin
        sel_o = '0;
        unique case (kind)
            KIND_ZERO: begin
                sel_o.upd    = 1'b1;
                sel_o.q_bit  = 1'b0;
                sel_o.qm_bit = 1'b1;
            end
            KIND_PLUS: begin
                sel_o.upd       = 1'b1;
                sel_o.qm_from_q = 1'b1;
                sel_o.q_bit     = 1'b1;
                sel_o.qm_bit    = 1'b0;
            end
            KIND_MINUS: begin
                sel_o.upd       = 1'b1;
                sel_o.q_from_qm = 1'b1;
                sel_o.q_bit     = 1'b1;
                sel_o.qm_bit    = 1'b0;
            end
            default: sel_o = '0;
        endcase
    end

endmodule

// File: rtl/otf_shift_append.sv
module otf_shift_append #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] src_i,
    input  logic         bit_i,
    output logic [W-1:0] res_o
);

    generate
        if (W == 1) begin : g_single
            logic unused_src;
            assign unused_src = src_i[0];
            assign res_o = bit_i;
        end else begin : g_wide
            logic unused_msb;
            assign unused_msb = src_i[W-1];
            assign res_o = {src_i[W-2:0], bit_i};
        end
    endgenerate

endmodule

// File: rtl/otf_quotient_conv.sv
module otf_quotient_conv
    import otf_pkg::*;
#(
    parameter int unsigned QW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          dig_valid_i,
    input  logic [1:0]    dig_code_i,
    output logic [QW-1:0] q_o,
    output logic [QW-1:0] qm_o
);

    typedef struct packed {
        logic [QW-1:0] q;
        logic [QW-1:0] qm;
    } acc_t;

    localparam acc_t ACC_INIT = '{q: '0, qm: '1};

    acc_t     acc_d, acc_q;
    dig_sel_t sel;
    logic [QW-1:0] q_src, qm_src, q_next, qm_next;

    otf_digit_decode u_dec (
        .valid_i (dig_valid_i),
        .code_i  (dig_code_i),
        .sel_o   (sel)
    );

    assign q_src  = sel.q_from_qm ? acc_q.qm : acc_q.q;
    assign qm_src = sel.qm_from_q ? acc_q.q  : acc_q.qm;

    otf_shift_append #(.W(QW)) u_app_q (
        .src_i (q_src),
        .bit_i (sel.q_bit),
        .res_o (q_next)
    );

    otf_shift_append #(.W(QW)) u_app_qm (
        .src_i (qm_src),
        .bit_i (sel.qm_bit),
        .res_o (qm_next)
    );

    always_comb begin
        acc_d = acc_q;
        if (clear_i) begin
            acc_d = ACC_INIT;
        end else if (sel.upd) begin
            acc_d.q  = q_next;
            acc_d.qm = qm_next;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) acc_q <= ACC_INIT;
        else         acc_q <= acc_d;
    end

    assign q_o  = acc_q.q;
    assign qm_o = acc_q.qm;

endmodule

// File: rtl/otf_quotient_conv_chk.sv
module otf_quotient_conv_chk #(
    parameter int unsigned QW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          clear_i,
    input logic          dig_valid_i,
    input logic [1:0]    dig_code_i,
    input logic [QW-1:0] q_o,
    input logic [QW-1:0] qm_o
);

    localparam logic [QW-1:0] ONE = QW'(1);

    logic acc_zero, acc_plus, acc_minus, acc_rsvd;
    assign acc_zero  = !clear_i && dig_valid_i && dig_code_i == 2'b00;
    assign acc_plus  = !clear_i && dig_valid_i && dig_code_i == 2'b01;
    assign acc_minus = !clear_i && dig_valid_i && dig_code_i == 2'b11;
    assign acc_rsvd  = !clear_i && dig_valid_i && dig_code_i == 2'b10;

    a_r1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (q_o == '0 && qm_o == '1));

    a_r2_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_zero |=> (q_o == ($past(q_o) << 1) && qm_o == (($past(qm_o) << 1) | ONE)));

    a_r3_plus: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_plus |=> (q_o == (($past(q_o) << 1) | ONE) && qm_o == ($past(q_o) << 1)));

    a_r4_minus: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_minus |=> (q_o == (($past(qm_o) << 1) | ONE) && qm_o == ($past(qm_o) << 1)));

    a_r5_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_rsvd |=> ($stable(q_o) && $stable(qm_o)));

    a_r6_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !dig_valid_i) |=> ($stable(q_o) && $stable(qm_o)));

    a_r7_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        qm_o == q_o - ONE);

endmodule

bind otf_quotient_conv otf_quotient_conv_chk #(.QW(QW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .dig_valid_i (dig_valid_i),
    .dig_code_i  (dig_code_i),
    .q_o         (q_o),
    .qm_o        (qm_o)
);

// File: tb/otf_quotient_conv_tb_top.sv
`timescale 1ns/1ps
module otf_quotient_conv_tb_top;

    localparam int unsigned QW = 16;
    localparam logic [QW-1:0] ONE = QW'(1);

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          clear_i = 1'b0;
    logic          dig_valid_i = 1'b0;
    logic [1:0]    dig_code_i = 2'b00;
    logic [QW-1:0] q_o, qm_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    logic [QW-1:0] ref_q;

    always #5 clk = ~clk;

    otf_quotient_conv #(.QW(QW)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .clear_i     (clear_i),
        .dig_valid_i (dig_valid_i),
        .dig_code_i  (dig_code_i),
        .q_o         (q_o),
        .qm_o        (qm_o)
    );

    task automatic check(input string req, input logic [QW-1:0] act, input logic [QW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference: value*2 + digit, modulo 2^QW (R8)
    function automatic logic [QW-1:0] ref_step(input logic [QW-1:0] v, input logic [1:0] code);
        case (code)
            2'b00:   return v << 1;
            2'b01:   return (v << 1) + ONE;
            2'b11:   return (v << 1) - ONE;
            default: return v;
        endcase
    endfunction

    task automatic send(input logic [1:0] code);
        @(negedge clk);
        dig_valid_i = 1'b1;
        dig_code_i  = code;
        @(negedge clk);
        dig_valid_i = 1'b0;
        ref_q = ref_step(ref_q, code);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        ref_q = '0;
    endtask

    task automatic t_reset();
        check("R1 reset q", q_o, '0);
        check("R1 reset qm", qm_o, '1);
        check("R7 reset offset", qm_o, q_o - ONE);
    endtask

    task automatic t_single_codes();
        logic [QW-1:0] pq, pqm;
        do_clear();
        send(2'b01); send(2'b01); send(2'b00);   // q = 6
        pq = q_o; pqm = qm_o;
        send(2'b00);
        check("R2 zero q", q_o, pq << 1);
        check("R2 zero qm", qm_o, (pqm << 1) | ONE);
        pq = q_o; pqm = qm_o;
        send(2'b01);
        check("R3 plus q", q_o, (pq << 1) | ONE);
        check("R3 plus qm", qm_o, pq << 1);
        pq = q_o; pqm = qm_o;
        send(2'b11);
        check("R4 minus q", q_o, (pqm << 1) | ONE);
        check("R4 minus qm", qm_o, pqm << 1);
        check("R8 short", q_o, ref_q);
    endtask

    task automatic t_negative_start();
        do_clear();
        send(2'b11);
        check("R4 first minus q", q_o, '1);
        check("R7 first minus qm", qm_o, '1 - ONE);
        send(2'b11); send(2'b01);
        check("R8 negative start", q_o, ref_q);
    endtask

    task automatic t_reserved_and_idle();
        logic [QW-1:0] pq, pqm;
        do_clear();
        send(2'b01); send(2'b11); send(2'b01);
        pq = q_o; pqm = qm_o;
        send(2'b10);
        check("R5 reserved q", q_o, pq);
        check("R5 reserved qm", qm_o, pqm);
        @(negedge clk); dig_code_i = 2'b01;
        repeat (4) @(negedge clk);
        check("R6 idle q", q_o, pq);
        check("R6 idle qm", qm_o, pqm);
    endtask

    task automatic t_clear_priority();
        send(2'b01);
        @(negedge clk);
        clear_i = 1'b1; dig_valid_i = 1'b1; dig_code_i = 2'b01;
        @(negedge clk);
        clear_i = 1'b0; dig_valid_i = 1'b0;
        ref_q = '0;
        check("R1 clear over digit q", q_o, '0);
        check("R1 clear over digit qm", qm_o, '1);
    endtask

    task automatic t_long_stream();
        logic [15:0] lfsr = 16'hACE1;
        logic [1:0]  c;
        do_clear();
        for (int i = 0; i < 3 * QW + 5; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[1:0])
                2'b00: c = 2'b00;
                2'b01: c = 2'b01;
                default: c = 2'b11;
            endcase
            send(c);
            check("R7 stream offset", qm_o, q_o - ONE);
        end
        check("R8 long stream", q_o, ref_q);
    endtask

    initial begin
        ref_q = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk);
        t_single_codes();
        t_negative_start();
        t_reserved_and_idle();
        t_clear_priority();
        t_long_stream();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule